// File: doc/BRIEF.md
# Nearest-Match Associative Cache

This block is a content-addressed store of binary hypervector keys. A lookup returns the stored entry that resembles the query most closely, rather than requiring an exact match. Each entry holds a projected binary key, a value index and a valid flag. Entries are loaded, replaced or dropped through a single write port.

A lookup compares the query against every entry at once. The similarity between the query and an entry is the number of bit positions in which they agree, which is the popcount of their XNOR. Counting agreeing positions is the bipolar dot product shifted and scaled, so the ranking is the same.

The match scores of all entries are registered in a first stage. A second stage reduces them to the winner, and the result appears a fixed two cycles after the query is accepted, however many entries are occupied. The result carries the winning entry index, its score, its stored value and a hit flag. The hit flag is raised only when the best score reaches a threshold that is supplied with the query.

The default parameters are deliberately small. The entry count and key width are parameters, so the same code instance covers a 256-entry store of 1024-bit keys.

Top module: `nm_assoc_cache`

## Requirements
- R1: After reset `res_valid` and `res_hit` are low and every entry is invalid, so a lookup with threshold 0 returns `res_hit`=0.
- R2: A cycle with `wr_en`=1 stores `wr_key` and `wr_val` at entry `wr_idx`. The entry is marked valid when `wr_keep`=1 and invalid when `wr_keep`=0. Later writes to the same index replace the earlier ones.
- R3: The score of an entry is the count of bit positions where its key equals the query key, from 0 to KEY_W. `res_score` reports the score of the winning entry.
- R4: Among the valid entries, the winner is an entry with the largest score. `res_idx` and `res_value` report that entry's index and stored value.
- R5: When several valid entries share the largest score, the lowest index wins.
- R6: Invalid entries never win. When no entry is valid, `res_idx`, `res_score` and `res_value` are all 0 and `res_hit` is 0.
- R7: `res_hit` is 1 exactly when some entry is valid and the best score is greater than or equal to the `thr` value sampled together with the query.
- R8: A query presented with `lk_req`=1 at a rising edge produces `res_valid`=1 for one cycle, starting after the second rising edge that follows it. Queries may be issued on back-to-back cycles, and each one yields its own result.
- R9: A lookup sees the entries as they stood before its acceptance edge. A write in the same cycle or in a later cycle does not change that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IW | Entry index to write |
| wr_key | input | KEY_W | Key to store |
| wr_val | input | VAL_W | Value index to store |
| wr_keep | input | 1 | 1 marks the entry valid, 0 invalidates it |
| lk_req | input | 1 | Query strobe |
| lk_key | input | KEY_W | Query key |
| thr | input | SW | Hit threshold, sampled with the query |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Best score reached the threshold |
| res_idx | output | IW | Winning entry index |
| res_score | output | SW | Agreeing-bit count of the winner |
| res_value | output | VAL_W | Stored value of the winner |

## Verification
The bench fills an 8-entry, 16-bit configuration with computed keys and sweeps thousands of query words against it. A reference scan computes the expected index, score and value for each query, which separates errors in counting agreeing bits from errors in choosing the maximum.

Queries are also made against duplicated keys, which exposes a wrong tie order. Other queries target invalidated entries, to catch stale winners, and query an empty store to check the zeroed result. A pair of queries at threshold equal to the score and one above it pins the comparison edge.

Back-to-back queries and writes made in the same cycle as a query, or in the cycle after it, show whether results arrive at the stated cycle and whether they are taken from the right snapshot.

// File: rtl/nm_assoc_cache.sv
module nm_assoc_cache #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 64,
  parameter int VAL_W   = 8,
  localparam int IW = $clog2(ENTRIES),
  localparam int SW = $clog2(KEY_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             wr_keep,
  input  logic             lk_req,
  input  logic [KEY_W-1:0] lk_key,
  input  logic [SW-1:0]    thr,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IW-1:0]    res_idx,
  output logic [SW-1:0]    res_score,
  output logic [VAL_W-1:0] res_value
);

  logic [KEY_W-1:0] key_q [ENTRIES];
  logic [VAL_W-1:0] val_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx] <= wr_key;
      val_q[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_keep;
  end

  logic               s1_req;
  logic [SW-1:0]      s1_thr;
  logic [ENTRIES-1:0] s1_vld;
  logic [SW-1:0]      s1_score [ENTRIES];
  logic [VAL_W-1:0]   s1_val [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) s1_req <= 1'b0;
    else        s1_req <= lk_req;
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      s1_thr <= thr;
      s1_vld <= vld_q;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lk_req) begin
        s1_score[g] <= SW'($countones(~(lk_key ^ key_q[g])));
        s1_val[g]   <= val_q[g];
      end
    end
  end

  logic          found;
  logic [SW-1:0] best_s;
  logic [IW-1:0] best_i;

  always_comb begin
    found  = 1'b0;
    best_s = '0;
    best_i = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (s1_vld[i] && (!found || s1_score[i] > best_s)) begin
        found  = 1'b1;
        best_s = s1_score[i];
        best_i = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_score <= '0;
      res_value <= '0;
    end else begin
      res_valid <= s1_req;
      if (s1_req) begin
        res_hit   <= found && (best_s >= s1_thr);
        res_idx   <= best_i;
        res_score <= best_s;
        res_value <= found ? s1_val[best_i] : '0;
      end
    end
  end

  logic [ENTRIES-1:0] vld_h1, vld_h2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_h1 <= '0;
      vld_h2 <= '0;
    end else begin
      vld_h1 <= vld_q;
      vld_h2 <= vld_h1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> ##1 res_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(lk_req, 2)); // R8
  AST_HIT_THR: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_hit) |-> res_score >= $past(thr, 2)); // R7
  AST_WIN_VALID: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && res_hit) |-> vld_h2[res_idx]); // R6
  AST_SCORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> res_score <= SW'(KEY_W)); // R3

endmodule

// File: tb/test_nm_assoc_cache.sv
module test_nm_assoc_cache;
  localparam int N = 8, KW = 16, VW = 4;
  localparam int IW = $clog2(N), SW = $clog2(KW + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_keep = 0, lk_req = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [KW-1:0] wr_key = '0, lk_key = '0;
  logic [VW-1:0] wr_val = '0;
  logic [SW-1:0] thr = '0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_idx;
  logic [SW-1:0] res_score;
  logic [VW-1:0] res_value;

  nm_assoc_cache #(.ENTRIES(N), .KEY_W(KW), .VAL_W(VW)) i_nm_assoc_cache (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_key, .wr_val, .wr_keep,
    .lk_req, .lk_key, .thr, .res_valid, .res_hit, .res_idx, .res_score, .res_value);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [KW-1:0] mkey [N];
  logic [VW-1:0] mval [N];
  logic [N-1:0]  mvld = '0;
  logic          e_hit;
  logic [IW-1:0] e_idx;
  logic [SW-1:0] e_sc;
  logic [VW-1:0] e_val;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_for(logic [KW-1:0] q, logic [SW-1:0] t);
    bit f = 0;
    int bs = 0, bi = 0;
    for (int i = 0; i < N; i++) begin
      int s = $countones(~(q ^ mkey[i]));
      if (mvld[i] && (!f || s > bs)) begin f = 1; bs = s; bi = i; end
    end
    e_hit = f && (bs >= t);
    e_idx = f ? IW'(bi) : '0;
    e_sc  = f ? SW'(bs) : '0;
    e_val = f ? mval[bi] : '0;
  endtask

  task automatic compare(string req);
    chk({req, " valid"}, res_valid, 1);
    chk({req, " hit"}, res_hit, e_hit);
    chk({req, " idx"}, res_idx, e_idx);
    chk({req, " score"}, res_score, e_sc);
    chk({req, " value"}, res_value, e_val);
  endtask

  task automatic wr(int idx, logic [KW-1:0] k, logic [VW-1:0] v, bit keep);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_key = k; wr_val = v; wr_keep = keep;
    @(negedge clk);
    wr_en = 0;
    mkey[idx] = k; mval[idx] = v; mvld[idx] = keep;
  endtask

  task automatic look(logic [KW-1:0] q, logic [SW-1:0] t, string req);
    expect_for(q, t);
    @(negedge clk);
    lk_req = 1; lk_key = q; thr = t;
    @(negedge clk);
    lk_req = 0;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mkey[i] = '0; mval[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", res_valid, 0);
    chk("R1 hit after reset", res_hit, 0);
    rst_n = 1;
    look(16'hA5A5, 0, "R1 R6 empty");

    // R2: fill entries with computed keys
    for (int i = 0; i < N; i++)
      wr(i, KW'((i * 16'h9E37 + 16'h1234) ^ (i << 11)), VW'(i + 3), 1);
    for (int i = 0; i < N; i++) look(mkey[i], SW'(KW), "R2 R3 exact");

    // R3 R4: sweep
    for (int q = 0; q < 6000; q++)
      look(KW'(q * 11 ^ (q << 7)), SW'(q % 18), "R4 R7 sweep");

    // R5: tie between duplicates
    wr(5, 16'h0F0F, 4'h9, 1);
    wr(2, 16'h0F0F, 4'h6, 1);
    look(16'h0F0F, 0, "R5 tie exact");
    look(16'h0F0E, 0, "R5 tie near");
    chk("R5 lowest index", res_idx, 2);

    // R6: invalidate winner
    wr(2, 16'h0F0F, 4'h6, 0);
    look(16'h0F0F, 0, "R6 invalid skipped");
    chk("R6 next winner", res_idx, 5);

    // R7: threshold edge
    look(16'h0F0F, SW'(KW), "R7 thr equal");
    chk("R7 hit at equal", res_hit, 1);
    look(16'h0F0E, SW'(KW), "R7 thr above");
    chk("R7 miss above", res_hit, 0);

    // R8: back-to-back queries and timing
    begin
      logic e1h, e2h; logic [IW-1:0] e1i, e2i; logic [SW-1:0] e1s, e2s;
      expect_for(16'h0F0F, 0); e1h = e_hit; e1i = e_idx; e1s = e_sc;
      expect_for(mkey[0], 0);  e2h = e_hit; e2i = e_idx; e2s = e_sc;
      @(negedge clk); lk_req = 1; lk_key = 16'h0F0F; thr = 0;
      @(negedge clk); lk_key = mkey[0];
      chk("R8 not yet valid", res_valid, 0);
      @(negedge clk); lk_req = 0;
      chk("R8 first valid", res_valid, 1);
      chk("R8 first idx", res_idx, e1i);
      chk("R8 first score", res_score, e1s);
      chk("R8 first hit", res_hit, e1h);
      @(negedge clk);
      chk("R8 second valid", res_valid, 1);
      chk("R8 second idx", res_idx, e2i);
      chk("R8 second score", res_score, e2s);
      chk("R8 second hit", res_hit, e2h);
      @(negedge clk);
      chk("R8 single pulse", res_valid, 0);
    end

    // R9: same-cycle write and next-cycle write
    expect_for(mkey[4], 0);
    @(negedge clk);
    lk_req = 1; lk_key = mkey[4]; thr = 0;
    wr_en = 1; wr_idx = 4; wr_key = ~mkey[4]; wr_val = 4'hF; wr_keep = 1;
    @(negedge clk);
    lk_req = 0; wr_idx = 5; wr_keep = 0;
    @(negedge clk);
    wr_en = 0;
    compare("R9 snapshot");
    mkey[4] = ~mkey[4]; mval[4] = 4'hF; mvld[5] = 0;
    look(mkey[4], 0, "R9 after write");
    chk("R2 overwrite value", res_value, 15);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule